// File: doc/BRIEF.md
# Timestamp Compare Marker Pulse Generator

This block turns a free-running timestamp into a timed marker pulse, for example a once-per-second output. A 32-bit counter advances on every reference-clock cycle. Software programs a 32-bit target value, a 16-bit pulse width and an output sense through a small write-only register port. When the counter reaches the target, a four-state machine waits out a fixed lead time and then holds the marker output active for the programmed number of cycles. When the pulse starts, it also queues a record in an eight-entry event queue, which software drains through a pop strobe.

The state machine has four states. ST_IDLE waits for a hit, which is the counter equal to the target with a non-zero width. The hit takes it to ST_ARM1, and it captures the target and the width at that moment. ST_ARM1 always moves on to ST_ARM2. ST_ARM2 always moves on to ST_PULSE and pushes the event record at that edge. ST_PULSE counts the captured width down and returns to ST_IDLE after its last active cycle. A hit is only taken in ST_IDLE, so register writes and further hits during a pulse leave that pulse alone.

Register writes use `wr_addr`. Address 0 loads the target. Address 1 loads the width from data bits 15:0. Address 2 loads the sense from data bit 0. Address 3 is unused.

Top module: `ts_marker_top`

## Requirements
- R1: After reset the timestamp counter reads 0 and rises by exactly one every clock cycle, modulo 2^32.
- R2: When the counter equals the target in cycle t and the width is non-zero, the marker output takes its active level first in cycle t+3.
- R3: The active level lasts exactly the programmed number of cycles. The width used is the one held in the cycle of the hit.
- R4: With a width of zero, a match produces neither an active level nor an event record.
- R5: Sense bit 1 makes the output active high and sense bit 0 makes it active low. When no pulse is running, the output sits at the opposite of the active level, and it follows a change of the sense bit in the very next cycle.
- R6: Writes to the target or the width during a pending or running pulse do not shorten, restart or extend it. Matches arising in that time are ignored, and the new values act on the next match after the return to idle.
- R7: In the first cycle the output is active, an event record becomes visible in the queue. Its type field reads 4'h5 and its value field holds the target that fired. Records leave the queue in arrival order.
- R8: The queue holds 8 records. A push onto a full queue is dropped and sets a sticky overflow flag, unless a pop happens in the same cycle, in which case the push is kept. The flag is cleared only by reset.
- R9: Synchronous active-high reset clears the counter, the state machine and the queue, sets the width and target to 0 and the sense to active low. The output therefore reads 1 right after reset.
- R10: The register port decodes address 0 as target, 1 as width (data bits 15:0) and 2 as sense (data bit 0). A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Register write data |
| ev_pop | input | 1 | Removes the head record from the event queue |
| ts_count | output | 32 | Current timestamp |
| mark_out | output | 1 | Marker pulse output |
| ev_valid | output | 1 | Event queue is not empty |
| ev_type | output | 4 | Type field of the head record |
| ev_value | output | 32 | Target value stored in the head record |
| ev_overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
The two functions that can fall in one cycle are the event push, made at the ST_ARM2 to ST_PULSE edge, and a software pop of the queue. The case that matters is when the queue is full. The bench first fills the queue with eight short pulses. It then programs a new target and raises `ev_pop` in exactly the ST_ARM2 cycle, which is two cycles after the counter meets the target. The run is judged correct if the overflow flag stays clear and a later drain returns the seven older values followed by the new target in order. A cycle-level scoreboard model compares every queue head and every output level with the expected values.

// File: rtl/ts_marker_pkg.sv
package ts_marker_pkg;

    localparam int ADDR_W    = 2;
    localparam int EV_TYPE_W = 4;

    localparam logic [ADDR_W-1:0]    REG_TARGET = 2'd0;
    localparam logic [ADDR_W-1:0]    REG_WIDTH  = 2'd1;
    localparam logic [ADDR_W-1:0]    REG_SENSE  = 2'd2;

    localparam logic [EV_TYPE_W-1:0] EV_CMP_CODE = 4'h5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM1  = 2'd1,
        ST_ARM2  = 2'd2,
        ST_PULSE = 2'd3
    } mark_state_t;

endpackage

// File: rtl/ts_marker_counter.sv
module ts_marker_counter #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] ts
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ts <= '0;
        end else begin
            ts <= ts + 1'b1;
        end
    end

endmodule

// File: rtl/ts_marker_regs.sv
module ts_marker_regs
    import ts_marker_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TS_W-1:0]   wr_data,
    output logic [TS_W-1:0]   target_q,
    output logic [LEN_W-1:0]  width_q,
    output logic              sense_q
);

    logic unused_hi_bits;
    assign unused_hi_bits = ^wr_data[TS_W-1:LEN_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
            width_q  <= '0;
            sense_q  <= 1'b0;
        end else if (wr_en) begin
            unique case (wr_addr)
                REG_TARGET: target_q <= wr_data;
                REG_WIDTH:  width_q  <= wr_data[LEN_W-1:0];
                REG_SENSE:  sense_q  <= wr_data[0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/ts_marker_fsm.sv
module ts_marker_fsm
    import ts_marker_pkg::*;
#(
    parameter int TS_W  = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [TS_W-1:0]  ts,
    input  logic [TS_W-1:0]  target,
    input  logic [LEN_W-1:0] width,
    output logic             hit_take,
    output logic             in_idle,
    output logic             pulse_on,
    output logic             push_evt,
    output logic [TS_W-1:0]  evt_target,
    output logic [LEN_W-1:0] remain
);

    mark_state_t      state_q;
    mark_state_t      state_d;
    logic [TS_W-1:0]  snap_target;
    logic [LEN_W-1:0] snap_width;
    logic             hit;

    assign hit = (ts == target) && (width != '0);

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (hit) state_d = ST_ARM1;
            ST_ARM1:  state_d = ST_ARM2;
            ST_ARM2:  state_d = ST_PULSE;
            ST_PULSE: if (remain == LEN_W'(1)) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // captured target, width and the running down-counter
    always_ff @(posedge clk) begin
        if (rst) begin
            snap_target <= '0;
            snap_width  <= '0;
            remain      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (hit) begin
                        snap_target <= target;
                        snap_width  <= width;
                    end
                end
                ST_ARM1:  ;
                ST_ARM2:  remain <= snap_width;
                ST_PULSE: remain <= remain - 1'b1;
                default:  ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        hit_take   = 1'b0;
        in_idle    = 1'b0;
        pulse_on   = 1'b0;
        push_evt   = 1'b0;
        evt_target = snap_target;
        unique case (state_q)
            ST_IDLE: begin
                in_idle  = 1'b1;
                hit_take = hit;
            end
            ST_ARM1:  ;
            ST_ARM2:  push_evt = 1'b1;
            ST_PULSE: pulse_on = 1'b1;
            default:  ;
        endcase
    end

endmodule

// File: rtl/ts_marker_evq.sv
module ts_marker_evq #(
    parameter int DEPTH   = 8,
    parameter int ENTRY_W = 36
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [ENTRY_W-1:0]           push_data,
    input  logic                         pop,
    output logic [ENTRY_W-1:0]           head,
    output logic                         valid,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ENTRY_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic               full;
    logic               take;
    logic               put;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CNT_W'(DEPTH));
    assign valid = (count != '0);
    assign take  = pop && valid;
    assign put   = push && (!full || take);
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (put) begin
            slots[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (put)  wr_ptr <= step(wr_ptr);
            if (take) rd_ptr <= step(rd_ptr);
            unique case ({put, take})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
            if (push && !put) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/ts_marker_top.sv
module ts_marker_top
    import ts_marker_pkg::*;
#(
    parameter int TS_W     = 32,
    parameter int LEN_W    = 16,
    parameter int EV_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [TS_W-1:0]      wr_data,
    input  logic                 ev_pop,
    output logic [TS_W-1:0]      ts_count,
    output logic                 mark_out,
    output logic                 ev_valid,
    output logic [EV_TYPE_W-1:0] ev_type,
    output logic [TS_W-1:0]      ev_value,
    output logic                 ev_overflow
);

    localparam int ENTRY_W = EV_TYPE_W + TS_W;
    localparam int CNT_W   = $clog2(EV_DEPTH + 1);

    logic [TS_W-1:0]    target_q;
    logic [LEN_W-1:0]   width_q;
    logic               sense_q;
    logic               cmp_accept;
    logic               fsm_idle;
    logic               pulse_on;
    logic               push_evt;
    logic [TS_W-1:0]    evt_target;
    logic [LEN_W-1:0]   remain_cnt;
    logic [ENTRY_W-1:0] head_entry;
    logic [CNT_W-1:0]   fifo_cnt;

    ts_marker_counter #(.TS_W(TS_W)) u_counter (
        .clk (clk),
        .rst (rst),
        .ts  (ts_count)
    );

    ts_marker_regs #(.TS_W(TS_W), .LEN_W(LEN_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .target_q (target_q),
        .width_q  (width_q),
        .sense_q  (sense_q)
    );

    ts_marker_fsm #(.TS_W(TS_W), .LEN_W(LEN_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .ts         (ts_count),
        .target     (target_q),
        .width      (width_q),
        .hit_take   (cmp_accept),
        .in_idle    (fsm_idle),
        .pulse_on   (pulse_on),
        .push_evt   (push_evt),
        .evt_target (evt_target),
        .remain     (remain_cnt)
    );

    ts_marker_evq #(.DEPTH(EV_DEPTH), .ENTRY_W(ENTRY_W)) u_evq (
        .clk       (clk),
        .rst       (rst),
        .push      (push_evt),
        .push_data ({EV_CMP_CODE, evt_target}),
        .pop       (ev_pop),
        .head      (head_entry),
        .valid     (ev_valid),
        .count     (fifo_cnt),
        .overflow  (ev_overflow)
    );

    assign ev_type  = head_entry[ENTRY_W-1:TS_W];
    assign ev_value = head_entry[TS_W-1:0];
    assign mark_out = sense_q ? pulse_on : ~pulse_on;

endmodule

// File: rtl/ts_marker_chk.sv
module ts_marker_chk #(
    parameter int TS_W     = 32,
    parameter int LEN_W    = 16,
    parameter int EV_DEPTH = 8,
    parameter int CNT_W    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [TS_W-1:0]  ts_count,
    input logic [TS_W-1:0]  target_q,
    input logic [LEN_W-1:0] width_q,
    input logic             sense_q,
    input logic             cmp_accept,
    input logic             fsm_idle,
    input logic             pulse_on,
    input logic [LEN_W-1:0] remain_cnt,
    input logic             mark_out,
    input logic             ev_valid,
    input logic             ev_overflow,
    input logic [CNT_W-1:0] fifo_cnt
);

    assert_ts_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ts_count == $past(ts_count) + 1'b1);

    assert_lead_R2: assert property (@(posedge clk) disable iff (rst)
        cmp_accept |=> !pulse_on ##1 !pulse_on ##1 pulse_on);

    assert_zero_width_R4: assert property (@(posedge clk) disable iff (rst)
        (fsm_idle && ts_count == target_q && width_q == '0) |=> fsm_idle);

    assert_idle_level_R5: assert property (@(posedge clk) disable iff (rst)
        fsm_idle |-> mark_out == ~sense_q);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (pulse_on && remain_cnt != LEN_W'(1)) |=> pulse_on);

    assert_push_on_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_on) |-> (ev_valid || ev_overflow));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(EV_DEPTH));

    assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ev_overflow)) |-> ev_overflow);

endmodule

bind ts_marker_top ts_marker_chk #(
    .TS_W     (TS_W),
    .LEN_W    (LEN_W),
    .EV_DEPTH (EV_DEPTH),
    .CNT_W    (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ts_count    (ts_count),
    .target_q    (target_q),
    .width_q     (width_q),
    .sense_q     (sense_q),
    .cmp_accept  (cmp_accept),
    .fsm_idle    (fsm_idle),
    .pulse_on    (pulse_on),
    .remain_cnt  (remain_cnt),
    .mark_out    (mark_out),
    .ev_valid    (ev_valid),
    .ev_overflow (ev_overflow),
    .fifo_cnt    (fifo_cnt)
);

// File: tb/test_ts_marker_top.sv
module test_ts_marker_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic        pop_req = 1'b0;
    logic [31:0] ts_count;
    logic        mark_out;
    logic        ev_valid;
    logic [3:0]  ev_type;
    logic [31:0] ev_value;
    logic        ev_overflow;

    int checks = 0;
    int fails  = 0;
    bit started = 1'b0;

    // scoreboard model state
    longint      cyc;
    longint      start_cyc;
    longint      end_cyc;
    logic [31:0] m_ts;
    logic [31:0] m_target;
    logic [15:0] m_width;
    logic        m_sense;
    logic        m_ovf;
    logic [31:0] pend_val;
    logic [31:0] sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ts_marker_top i_ts_marker_top (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .ev_pop      (pop_req),
        .ts_count    (ts_count),
        .mark_out    (mark_out),
        .ev_valid    (ev_valid),
        .ev_type     (ev_type),
        .ev_value    (ev_value),
        .ev_overflow (ev_overflow)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // model: built from the requirements, advances at each rising edge
    always @(posedge clk) begin
        if (rst) begin
            cyc = 0; start_cyc = 0; end_cyc = 0; m_ts = 0;
            m_target = 0; m_width = 0; m_sense = 1'b0; m_ovf = 1'b0;
            pend_val = 0;
            sb_q.delete();
        end else begin
            if (m_ts == m_target && m_width != 0 && cyc >= end_cyc) begin
                start_cyc = cyc + 3;
                end_cyc   = cyc + 3 + longint'(m_width);
                pend_val  = m_target;
            end
            if (pop_req && sb_q.size() > 0) void'(sb_q.pop_front());
            if (cyc + 1 == start_cyc) begin
                if (sb_q.size() < 8) sb_q.push_back(pend_val);
                else m_ovf = 1'b1;
            end
            if (wr_en) begin
                case (wr_addr)
                    2'd0: m_target = wr_data;
                    2'd1: m_width  = wr_data[15:0];
                    2'd2: m_sense  = wr_data[0];
                    default: ;
                endcase
            end
            cyc  = cyc + 1;
            m_ts = m_ts + 1;
        end
    end

    // monitor: compares outputs away from the active edge
    always @(negedge clk) begin
        if (started && !rst) begin
            bit act;
            act = (cyc >= start_cyc) && (cyc < end_cyc);
            chk(ts_count == m_ts, "R1 ts_count", ts_count, m_ts);
            chk(mark_out == (m_sense ? act : !act), "R2 R3 R5 R6 mark_out",
                mark_out, (m_sense ? act : !act));
            chk(ev_valid == (sb_q.size() > 0), "R7 ev_valid", ev_valid, sb_q.size() > 0);
            if (ev_valid && sb_q.size() > 0) begin
                chk(ev_value == sb_q[0], "R7 ev_value", ev_value, sb_q[0]);
                chk(ev_type == 4'h5, "R7 ev_type", ev_type, 4'h5);
            end
            chk(ev_overflow == m_ovf, "R8 ev_overflow", ev_overflow, m_ovf);
        end
    end

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire(input logic [15:0] w, input int off);
        write_reg(2'd1, {16'd0, w});
        write_reg(2'd0, ts_count + off);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        while (ev_valid) begin
            pop_req = 1'b1;
            @(negedge clk);
        end
        pop_req = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] t0;
        logic [31:0] base;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        started = 1'b1;
        // R9: reset state
        chk(ts_count == 0, "R9 ts after reset", ts_count, 0);
        chk(mark_out == 1'b1, "R9 idle level active low", mark_out, 1);
        chk(ev_valid == 1'b0, "R9 queue empty", ev_valid, 0);
        chk(ev_overflow == 1'b0, "R9 overflow clear", ev_overflow, 0);

        // R1: steady increment
        t0 = ts_count;
        idle(10);
        chk(ts_count == t0 + 10, "R1 ten cycles", ts_count, t0 + 10);

        // R2 R3 R7: active-low pulse of 4
        fire(16'd4, 8);
        base = ts_count + 7;
        idle(16);
        chk(ev_valid && ev_value == base, "R7 logged target", ev_value, base);
        drain();

        // R5: switch to active high, idle level drops next cycle
        write_reg(2'd2, 32'd1);
        chk(mark_out == 1'b0, "R5 idle level active high", mark_out, 0);
        fire(16'd3, 6);
        idle(15);
        drain();

        // R4: zero width, no pulse and no record
        write_reg(2'd1, 32'd0);
        write_reg(2'd0, ts_count + 4);
        idle(15);
        chk(ev_valid == 1'b0, "R4 no record for zero width", ev_valid, 0);

        // R6: rewrite width and target while a long pulse runs
        fire(16'd20, 4);
        idle(10);
        write_reg(2'd1, 32'd2);
        write_reg(2'd0, ts_count + 4);
        idle(30);
        chk(ev_valid == 1'b1, "R6 single record for long pulse", ev_valid, 1);
        write_reg(2'd0, ts_count + 5);
        idle(12);
        drain();

        // R10: address 3 writes change nothing
        write_reg(2'd3, 32'hFFFF_FFFF);
        chk(mark_out == 1'b0, "R10 sense unchanged", mark_out, 0);
        idle(5);

        // R8: fill the queue with active-low single-cycle pulses
        write_reg(2'd2, 32'd0);
        for (int k = 0; k < 8; k++) begin
            fire(16'd1, 3);
            idle(6);
        end
        chk(ev_overflow == 1'b0, "R8 exactly full, no overflow", ev_overflow, 0);
        // push and pop in the same cycle on a full queue
        base = ts_count;
        write_reg(2'd0, base + 4);
        while (ts_count != base + 6) @(negedge clk);
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        idle(3);
        chk(ev_overflow == 1'b0, "R8 push kept during pop", ev_overflow, 0);
        // two more pushes with no pop
        for (int k = 0; k < 2; k++) begin
            fire(16'd1, 3);
            idle(6);
        end
        chk(ev_overflow == 1'b1, "R8 overflow set", ev_overflow, 1);
        drain();
        idle(3);
        chk(ev_overflow == 1'b1, "R8 overflow sticky", ev_overflow, 1);
        chk(ev_valid == 1'b0, "R8 drained", ev_valid, 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule